// File: doc/BRIEF.md
# Early-Termination Controller for Layered Decoding

A layered decoder updates its posteriors one row-block at a time, so it can test the parity of the rows it has just updated in the same step, with no separate parity pass. This controller takes those tests and makes the stopping decision. After each row-block update, the decoder sends the controller one beat. The beat holds the new posterior of every position of every row in the block, the hard decision each position held before the update, and a mask that marks padded dummy positions. For each row, the controller finds the hard decisions, checks even parity and notes whether any real position changed sign. It combines these results over an iteration and counts iterations. At each iteration boundary it reports one of three results: the codeword is valid, run another iteration, or decoding has failed.

Passing the parity checks inside the iterations is not enough to accept a word, because such a word can still be invalid. There are two ways to make the decision safe. In stability mode, every row of the iteration must also keep all of its hard decisions unchanged. In confirmation mode, an iteration that passes all parity checks starts a confirmation pass. The decoder sends every row-block again without updating it, and the word is accepted only if that whole pass has even parity.

Top module: `early_term_ctrl`

## Requirements
- R1: The hard decision of a position is the most significant (sign) bit of its LLR_W-bit two's-complement posterior: 1 for a negative value. Position p of row r in a beat uses posterior bits [(r*WEIGHT+p)*LLR_W +: LLR_W] and bit r*WEIGHT+p of the previous-decision and mask vectors.
- R2: A row passes parity when the XOR of its unmasked hard decisions is 0. A beat passes only if every row in it passes.
- R3: In stability mode (mode_confirm = 0), a row also fails if any unmasked position has a new hard decision that differs from its previous hard decision.
- R4: Positions whose mask bit is 0 have no effect on the parity test or the stability test.
- R5: The pass state of an iteration restarts at the first beat of each iteration. A failure in an earlier iteration has no effect on a later one. A failure in any of the NSUB beats of an iteration stops that iteration from succeeding.
- R6: In stability mode, an iteration whose NSUB beats all pass produces a one-cycle done_valid pulse in the cycle after the last beat. At the same time busy drops, and iter_used holds the number of iterations run (counting from 1).
- R7: In confirmation mode, an iteration whose beats all pass parity sets conf_active and produces no pulse. Sign changes are ignored in this mode. The next NSUB beats form the confirmation pass, and done_valid pulses if all of them pass parity.
- R8: A failed confirmation pass below the iteration limit ends with an iter_next pulse. The controller then returns to normal updates, and iter_used increases by one.
- R9: When iteration MAX_ITER (default 20) ends without success, including a failed confirmation in that iteration, done_fail pulses for one cycle, busy drops, and iter_used equals MAX_ITER.
- R10: Every other iteration boundary produces a one-cycle iter_next pulse. At most one of iter_next, done_valid and done_fail is high in any cycle.
- R11: After reset, busy, conf_active and all pulses are 0 and iter_used is 0. Beats are ignored while busy is low. A start pulse (re)begins a word at iteration 1 with busy high, even in the middle of a run.
- R12: The mode is captured on start. Changes to mode_confirm during a word have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new codeword |
| mode_confirm | input | 1 | 1 = confirmation mode, 0 = stability mode (sampled on start) |
| beat_valid | input | 1 | One row-block subiteration result is present |
| beat_post | input | ROWS*WEIGHT*LLR_W | Updated posteriors of all rows of the block |
| beat_prev_hd | input | ROWS*WEIGHT | Hard decisions held before the update |
| beat_mask | input | ROWS*WEIGHT | 1 = real position, 0 = padded dummy |
| busy | output | 1 | A word is being decoded |
| conf_active | output | 1 | The confirmation pass is in progress |
| iter_next | output | 1 | Pulse: run another iteration |
| done_valid | output | 1 | Pulse: valid codeword |
| done_fail | output | 1 | Pulse: known decoding failure |
| iter_used | output | $clog2(MAX_ITER+1) | Current iteration number; holds the final count after a word ends |

## Verification
The assertions check, on every cycle, the rules about outcomes and counters. At most one result pulse fires at a time. A valid or failure result always comes with busy low. A failure happens only at the iteration limit. Each continue pulse adds exactly one to the iteration count. A start always begins at iteration 1, and the confirmation flag is never set while idle. Only the bench scenarios can show whether each result is correct for the data. Those scenarios cover parity of sign bits with padding masked, detection of a sign change, the pass state restarting each iteration, and the confirmation pass accepting or rejecting. They also cover the exact iteration count at the limit and a mode change during a word being ignored.

// File: rtl/term_pkg.sv
package term_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_UPDATE  = 2'd1,
        PH_CONFIRM = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        VD_NONE  = 2'd0,
        VD_CONT  = 2'd1,
        VD_VALID = 2'd2,
        VD_FAIL  = 2'd3
    } verdict_e;

    typedef struct packed {
        logic parity_ok;
        logic stable;
    } row_flags_t;

    // Whether a beat counts as passing, given the phase and the captured mode.
    function automatic logic beat_pass(input logic par_ok, input logic stab_ok,
                                       input phase_e ph, input logic confirm_mode);
        return par_ok & (stab_ok | confirm_mode | (ph == PH_CONFIRM));
    endfunction

    // Result at an iteration boundary; go_conf means the confirmation pass starts instead.
    function automatic verdict_e boundary_verdict(input logic pass, input logic at_limit,
                                                  input logic go_conf);
        if (pass)
            return go_conf ? VD_NONE : VD_VALID;
        else if (at_limit)
            return VD_FAIL;
        else
            return VD_CONT;
    endfunction

endpackage

// File: rtl/term_row_eval.sv
module term_row_eval #(
    parameter int WEIGHT = 6,
    parameter int LLR_W  = 8
) (
    input  logic [WEIGHT*LLR_W-1:0] post,
    input  logic [WEIGHT-1:0]       prev_hd,
    input  logic [WEIGHT-1:0]       live,
    output term_pkg::row_flags_t    flags
);
    logic [WEIGHT-1:0] hd_new;

    generate
        for (genvar p = 0; p < WEIGHT; p++) begin : g_sign
            assign hd_new[p] = post[p*LLR_W + LLR_W - 1];
        end
    endgenerate

    assign flags.parity_ok = ~^(hd_new & live);
    assign flags.stable    = ~|((hd_new ^ prev_hd) & live);
endmodule

// File: rtl/term_beat_reduce.sv
module term_beat_reduce #(
    parameter int ROWS = 4
) (
    input  term_pkg::row_flags_t [ROWS-1:0] flags,
    output logic                            all_parity,
    output logic                            all_stable
);
    always_comb begin
        all_parity = 1'b1;
        all_stable = 1'b1;
        for (int r = 0; r < ROWS; r++) begin
            all_parity = all_parity & flags[r].parity_ok;
            all_stable = all_stable & flags[r].stable;
        end
    end
endmodule

// File: rtl/term_seq.sv
module term_seq
    import term_pkg::*;
#(
    parameter int NSUB     = 3,
    parameter int MAX_ITER = 20,
    localparam int SW = (NSUB > 1) ? $clog2(NSUB) : 1,
    localparam int IW = $clog2(MAX_ITER + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode_confirm,
    input  logic          beat_valid,
    input  logic          all_parity,
    input  logic          all_stable,
    output logic          busy,
    output logic          conf_active,
    output logic          iter_next,
    output logic          done_valid,
    output logic          done_fail,
    output logic [IW-1:0] iter_used
);
    phase_e         phase_q;
    logic [SW-1:0]  sub_q;
    logic [IW-1:0]  iter_q;
    logic           acc_q;
    logic           mode_q;
    verdict_e       verdict_q;

    logic           ok_now;
    logic           acc_now;
    logic           last_sub;
    logic           at_limit;
    logic           go_conf;
    verdict_e       verdict_now;

    always_comb begin
        ok_now      = beat_pass(all_parity, all_stable, phase_q, mode_q);
        acc_now     = ((sub_q == '0) ? 1'b1 : acc_q) & ok_now;
        last_sub    = (sub_q == SW'(NSUB - 1));
        at_limit    = (iter_q == IW'(MAX_ITER));
        go_conf     = (phase_q == PH_UPDATE) & mode_q;
        verdict_now = boundary_verdict(acc_now, at_limit, go_conf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            sub_q     <= '0;
            iter_q    <= '0;
            acc_q     <= 1'b1;
            mode_q    <= 1'b0;
            verdict_q <= VD_NONE;
        end else begin
            verdict_q <= VD_NONE;
            if (start) begin
                phase_q <= PH_UPDATE;
                sub_q   <= '0;
                iter_q  <= IW'(1);
                acc_q   <= 1'b1;
                mode_q  <= mode_confirm;
            end else if (beat_valid && phase_q != PH_IDLE) begin
                acc_q <= acc_now;
                if (!last_sub) begin
                    sub_q <= sub_q + SW'(1);
                end else begin
                    sub_q     <= '0;
                    verdict_q <= verdict_now;
                    case (verdict_now)
                        VD_NONE:  phase_q <= PH_CONFIRM;
                        VD_CONT: begin
                            phase_q <= PH_UPDATE;
                            iter_q  <= iter_q + IW'(1);
                        end
                        default:  phase_q <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    assign busy        = (phase_q != PH_IDLE);
    assign conf_active = (phase_q == PH_CONFIRM);
    assign iter_next   = (verdict_q == VD_CONT);
    assign done_valid  = (verdict_q == VD_VALID);
    assign done_fail   = (verdict_q == VD_FAIL);
    assign iter_used   = iter_q;
endmodule

// File: rtl/early_term_ctrl.sv
module early_term_ctrl #(
    parameter int ROWS     = 4,
    parameter int WEIGHT   = 6,
    parameter int LLR_W    = 8,
    parameter int NSUB     = 3,
    parameter int MAX_ITER = 20,
    localparam int NPOS = ROWS * WEIGHT,
    localparam int IW   = $clog2(MAX_ITER + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  mode_confirm,
    input  logic                  beat_valid,
    input  logic [NPOS*LLR_W-1:0] beat_post,
    input  logic [NPOS-1:0]       beat_prev_hd,
    input  logic [NPOS-1:0]       beat_mask,
    output logic                  busy,
    output logic                  conf_active,
    output logic                  iter_next,
    output logic                  done_valid,
    output logic                  done_fail,
    output logic [IW-1:0]         iter_used
);
    term_pkg::row_flags_t [ROWS-1:0] row_flags;
    logic all_parity;
    logic all_stable;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            term_row_eval #(.WEIGHT(WEIGHT), .LLR_W(LLR_W)) u_row (
                .post    (beat_post[r*WEIGHT*LLR_W +: WEIGHT*LLR_W]),
                .prev_hd (beat_prev_hd[r*WEIGHT +: WEIGHT]),
                .live    (beat_mask[r*WEIGHT +: WEIGHT]),
                .flags   (row_flags[r])
            );
        end
    endgenerate

    term_beat_reduce #(.ROWS(ROWS)) u_reduce (
        .flags      (row_flags),
        .all_parity (all_parity),
        .all_stable (all_stable)
    );

    term_seq #(.NSUB(NSUB), .MAX_ITER(MAX_ITER)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .mode_confirm (mode_confirm),
        .beat_valid   (beat_valid),
        .all_parity   (all_parity),
        .all_stable   (all_stable),
        .busy         (busy),
        .conf_active  (conf_active),
        .iter_next    (iter_next),
        .done_valid   (done_valid),
        .done_fail    (done_fail),
        .iter_used    (iter_used)
    );
endmodule

// File: rtl/early_term_ctrl_chk.sv
module early_term_ctrl_chk #(
    parameter int MAX_ITER = 20,
    localparam int IW = $clog2(MAX_ITER + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          conf_active,
    input logic          iter_next,
    input logic          done_valid,
    input logic          done_fail,
    input logic [IW-1:0] iter_used
);
    // R10: only one result per cycle
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({iter_next, done_valid, done_fail}) <= 1);

    // R6: a valid result leaves the controller idle
    p_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> !busy);

    // R9: failure only at the iteration limit, and idle afterwards
    p_fail_limit_r9: assert property (@(posedge clk) disable iff (rst)
        done_fail |-> (!busy && iter_used == IW'(MAX_ITER)));

    // R9: the iteration count stays within range while busy
    p_iter_range_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (iter_used >= IW'(1) && iter_used <= IW'(MAX_ITER)));

    // R8: each continue pulse comes with exactly one more iteration
    p_iter_step_r8: assert property (@(posedge clk) disable iff (rst)
        iter_next |-> (iter_used == $past(iter_used) + IW'(1)));

    // R11: start begins at iteration one in the update phase
    p_start_r11: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !conf_active && iter_used == IW'(1)));

    // R7: the confirmation pass only exists inside a busy word
    p_conf_busy_r7: assert property (@(posedge clk) disable iff (rst)
        conf_active |-> busy);
endmodule

bind early_term_ctrl early_term_ctrl_chk #(.MAX_ITER(MAX_ITER)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .conf_active (conf_active),
    .iter_next   (iter_next),
    .done_valid  (done_valid),
    .done_fail   (done_fail),
    .iter_used   (iter_used)
);

// File: tb/sim_early_term_ctrl.sv
`timescale 1ns/1ps
module sim_early_term_ctrl;
    localparam int ROWS     = 4;
    localparam int WEIGHT   = 6;
    localparam int LLR_W    = 8;
    localparam int NSUB     = 3;
    localparam int MAX_ITER = 20;
    localparam int NPOS     = ROWS * WEIGHT;
    localparam int IW       = $clog2(MAX_ITER + 1);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  start = 1'b0;
    logic                  mode_confirm = 1'b0;
    logic                  beat_valid = 1'b0;
    logic [NPOS*LLR_W-1:0] beat_post = '0;
    logic [NPOS-1:0]       beat_prev_hd = '0;
    logic [NPOS-1:0]       beat_mask = '0;
    logic                  busy, conf_active, iter_next, done_valid, done_fail;
    logic [IW-1:0]         iter_used;

    int checks = 0;
    int errors = 0;

    // reference state, built from the requirements
    bit m_busy = 0, m_conf = 0, m_mode = 0, m_acc = 1;
    int m_it = 0, m_sub = 0;

    always #2.5 clk = ~clk;

    early_term_ctrl #(.ROWS(ROWS), .WEIGHT(WEIGHT), .LLR_W(LLR_W),
                      .NSUB(NSUB), .MAX_ITER(MAX_ITER)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode_confirm(mode_confirm),
        .beat_valid(beat_valid), .beat_post(beat_post), .beat_prev_hd(beat_prev_hd),
        .beat_mask(beat_mask), .busy(busy), .conf_active(conf_active),
        .iter_next(iter_next), .done_valid(done_valid), .done_fail(done_fail),
        .iter_used(iter_used)
    );

    task automatic check1(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Fill a beat: row bad_row gets odd parity, row chg_row gets one real sign change.
    task automatic build(input int bad_row, input int chg_row);
        for (int r = 0; r < ROWS; r++) begin
            int first = -1;
            bit par = 0;
            for (int p = 0; p < WEIGHT; p++) begin
                int idx = r*WEIGHT + p;
                logic [31:0] v = $urandom;
                bit m = (($urandom % 4) != 0);
                beat_mask[idx] = m;
                beat_post[idx*LLR_W +: LLR_W] = v[LLR_W-1:0];
                // masked positions get arbitrary previous decisions (R4)
                beat_prev_hd[idx] = m ? v[LLR_W-1] : 1'($urandom % 2);
                if (m) begin
                    par ^= v[LLR_W-1];
                    if (first < 0) first = idx;
                end
            end
            if (first < 0) begin
                first = r*WEIGHT;
                beat_mask[first] = 1'b1;
                par ^= beat_post[first*LLR_W + LLR_W - 1];
                beat_prev_hd[first] = beat_post[first*LLR_W + LLR_W - 1];
            end
            if (par != (r == bad_row)) begin
                beat_post[first*LLR_W + LLR_W - 1] = ~beat_post[first*LLR_W + LLR_W - 1];
                beat_prev_hd[first] = ~beat_prev_hd[first];
            end
            if (r == chg_row) beat_prev_hd[first] = ~beat_prev_hd[first];
        end
    endtask

    task automatic start_word(input bit mode, input string req);
        @(negedge clk);
        start = 1'b1;
        mode_confirm = mode;
        @(posedge clk);
        #1;
        start = 1'b0;
        m_busy = 1; m_conf = 0; m_mode = mode; m_it = 1; m_sub = 0; m_acc = 1;
        check1(req, "busy after start", busy, 1);
        check1(req, "iter_used after start", iter_used, 1);
        check1(req, "conf_active after start", conf_active, 0);
    endtask

    task automatic beat(input int bad_row, input int chg_row, input bit mode_drive, input string req);
        bit ok_par, ok_st, ok, e_valid, e_fail, e_cont;
        build(bad_row, chg_row);
        @(negedge clk);
        beat_valid = 1'b1;
        mode_confirm = mode_drive;
        @(posedge clk);
        #1;
        beat_valid = 1'b0;
        ok_par = (bad_row < 0);
        ok_st  = (chg_row < 0);
        e_valid = 0; e_fail = 0; e_cont = 0;
        if (m_busy) begin
            ok = m_conf ? ok_par : (ok_par && (m_mode || ok_st));
            m_acc = ((m_sub == 0) ? 1'b1 : m_acc) & ok;
            if (m_sub == NSUB - 1) begin
                m_sub = 0;
                if (m_acc) begin
                    if (!m_conf && m_mode) m_conf = 1;
                    else begin m_busy = 0; m_conf = 0; e_valid = 1; end
                end else if (m_it == MAX_ITER) begin
                    m_busy = 0; m_conf = 0; e_fail = 1;
                end else begin
                    m_conf = 0; m_it++; e_cont = 1;
                end
            end else begin
                m_sub++;
            end
        end
        check1(req, "done_valid", done_valid, e_valid);
        check1(req, "done_fail", done_fail, e_fail);
        check1(req, "iter_next", iter_next, e_cont);
        check1(req, "busy", busy, m_busy);
        check1(req, "conf_active", conf_active, m_conf);
        if (m_busy || e_valid || e_fail) check1(req, "iter_used", iter_used, m_it);
    endtask

    // one iteration of NSUB beats; bad_sub gets a parity failure, chg_sub a sign change
    task automatic iteration(input int bad_sub, input int chg_sub, input string req);
        for (int s = 0; s < NSUB; s++)
            beat((s == bad_sub) ? int'($urandom % ROWS) : -1,
                 (s == chg_sub) ? int'($urandom % ROWS) : -1, m_mode, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check1("R11", "busy at reset", busy, 0);
        check1("R11", "iter_used at reset", iter_used, 0);
        check1("R11", "pulses at reset", {iter_next, done_valid, done_fail}, 0);
        check1("R11", "conf at reset", conf_active, 0);

        // beats while idle are ignored
        beat(-1, -1, 1'b0, "R11");
        beat(1, 2, 1'b1, "R11");

        // stability: clean first iteration
        start_word(1'b0, "R12");
        iteration(-1, -1, "R1,R2,R4,R6");

        // stability: a sign change blocks success, then a clean iteration
        start_word(1'b0, "R3");
        iteration(-1, 1, "R3,R10");
        iteration(-1, -1, "R6");

        // parity failure in the first beat, then in the last beat, then clean
        start_word(1'b0, "R5");
        iteration(0, -1, "R2,R5");
        iteration(NSUB-1, -1, "R5");
        iteration(-1, -1, "R5");

        // confirmation: sign changes ignored, confirmation accepts
        start_word(1'b1, "R7");
        iteration(-1, 0, "R7");
        iteration(-1, 2, "R7");

        // confirmation rejects, continue, then success at iteration three
        start_word(1'b1, "R8");
        iteration(-1, -1, "R7");
        iteration(1, -1, "R8");
        iteration(0, -1, "R8");
        iteration(-1, -1, "R8");
        iteration(-1, -1, "R8");

        // stability: limit reached
        start_word(1'b0, "R9");
        for (int i = 0; i < MAX_ITER; i++) iteration(0, -1, "R9");

        // confirmation failing at the last allowed iteration
        start_word(1'b1, "R9");
        for (int i = 0; i < MAX_ITER - 1; i++) iteration(2, -1, "R9");
        iteration(-1, -1, "R9");
        iteration(1, -1, "R9,R8");

        // restart in mid-word
        start_word(1'b0, "R11");
        iteration(0, -1, "R11");
        beat(-1, -1, 1'b0, "R11");
        start_word(1'b0, "R11");
        iteration(-1, -1, "R11");

        // random words with mode toggling mid-word
        for (int w = 0; w < 60; w++) begin
            start_word(1'($urandom % 2), "R12");
            for (int g = 0; g < 4 * NSUB * MAX_ITER && m_busy; g++)
                beat((($urandom % 10) == 0) ? int'($urandom % ROWS) : -1,
                     (($urandom % 10) == 0) ? int'($urandom % ROWS) : -1,
                     1'($urandom % 2), "R12,R10");
            check1("R12", "word finished", busy, 0);
            if (($urandom % 4) == 0) beat(-1, -1, 1'b0, "R11");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule